// File: doc/BRIEF.md
# Execution-Mode Direct-Switch Controller

This block keeps track of the execution mode a small processor runs in (full-speed, divided-speed or low-speed) and decides, on each sleep request from the CPU, whether the request is a direct switch between the full-speed and low-speed clocks. A direct switch does not halt the processor. The request is decoded against four control bits: standby enable, low-speed select, direct-switch enable and watchdog clock-source select.

Going down from full speed takes effect on the next clock edge. Going back up from low speed first waits out a settling time. A 3-bit field picks that time from eight powers of two, and the wait is counted on a low-speed tick. When either switch completes, the block pulses an interrupt request for one cycle. A sleep request that matches neither switch is handed on, unchanged, to the ordinary sleep logic. A sleep request that arrives during the settling wait is dropped.

Top module: `pwr_dt_ctrl`

## Requirements
- R1: `mode_o` encodes the active mode as 0 = full-speed, 1 = divided-speed and 2 = low-speed. The block is in the divided-speed mode when it sits in full-speed with `div_sel_i` = 1. The settling wait reports 2.
- R2: In full-speed mode with `div_sel_i` = 0, a sleep request with `stby_en_i`, `lowspd_sel_i`, `dt_en_i` and `wdt_src_i` all 1 gives `mode_o` = 2 and `clk_sel_o` = 1 on the next cycle.
- R3: In low-speed mode, a sleep request with `stby_en_i` = 1, `lowspd_sel_i` = 0, `dt_en_i` = 1 and `wdt_src_i` = 1 raises `busy_o` on the next cycle. While `busy_o` is high, `mode_o` stays 2 and `clk_sel_o` stays 1.
- R4: The settling wait lasts exactly 2^(`settle_sel_i`+3) low-speed ticks, counted after the cycle in which the request is taken. On the clock edge that consumes the last tick, `busy_o` falls, `mode_o` becomes 0 and `clk_sel_o` becomes 0.
- R5: `cpu_run_o` stays 1 in every mode, including during a switch and during the settling wait.
- R6: `dt_irq_o` is high for exactly one cycle: the cycle in which a direct switch has just changed the mode. It is low at all other times.
- R7: After reset the block is in full-speed mode, with `clk_sel_o`, `busy_o`, `dt_irq_o` and `sleep_fwd_o` all 0.
- R8: A sleep request that meets neither set of switch conditions, including any request made in divided-speed mode, produces a one-cycle pulse on `sleep_fwd_o` on the next cycle and leaves the mode unchanged.
- R9: A sleep request made while `busy_o` is high is dropped. It produces no `sleep_fwd_o` pulse, causes no mode change and does not alter the length of the settling wait.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lspd_tick_i | input | 1 | One-cycle enable marking each low-speed clock period |
| sleep_req_i | input | 1 | Sleep request strobe from the CPU |
| stby_en_i | input | 1 | Standby enable control bit |
| lowspd_sel_i | input | 1 | Low-speed select: target is low-speed when 1 |
| dt_en_i | input | 1 | Direct-switch enable control bit |
| wdt_src_i | input | 1 | Watchdog clock-source select control bit |
| div_sel_i | input | 1 | Divided clock selected while in full-speed |
| settle_sel_i | input | SEL_W | Settling-time select |
| mode_o | output | 2 | Current execution mode |
| clk_sel_o | output | 1 | 1 = CPU on the low-speed clock |
| busy_o | output | 1 | Settling wait in progress |
| dt_irq_o | output | 1 | Direct-switch interrupt request pulse |
| sleep_fwd_o | output | 1 | Non-direct sleep request passed on |
| cpu_run_o | output | 1 | CPU run enable |

## Verification
Several properties are checked on every cycle by the assertions. The interrupt pulse never lasts two cycles, and it appears only when the state has just changed. A forwarded request never coincides with a mode change. The settling state is held until the counter reports completion. The counter stays frozen on cycles without a tick. Some behaviours can only be shown by the bench scenarios: the exact tick count for each settling select, the decoding of each control-bit combination, the divided-speed reporting, and the fact that a request made mid-wait neither lengthens the wait nor leaks out as a forwarded request.

// File: rtl/pwr_dt_pkg.sv
package pwr_dt_pkg;

   typedef enum logic [1:0] {
      ST_FAST   = 2'd0,
      ST_SLOW   = 2'd1,
      ST_SETTLE = 2'd2
   } dt_state_e;

   localparam logic [1:0] MODE_FULL = 2'd0;
   localparam logic [1:0] MODE_DIV  = 2'd1;
   localparam logic [1:0] MODE_LOW  = 2'd2;

endpackage

// File: rtl/pwr_dt_decode.sv
module pwr_dt_decode (
   input  logic sleep_req_i,
   input  logic in_fast_i,
   input  logic in_slow_i,
   input  logic busy_i,
   input  logic div_sel_i,
   input  logic stby_en_i,
   input  logic lowspd_sel_i,
   input  logic dt_en_i,
   input  logic wdt_src_i,
   output logic go_slow_o,
   output logic go_fast_o,
   output logic fwd_o
);

   logic common_ok;

   always_comb begin
      common_ok = stby_en_i & dt_en_i & wdt_src_i;
      go_slow_o = sleep_req_i & in_fast_i & ~div_sel_i & common_ok & lowspd_sel_i;
      go_fast_o = sleep_req_i & in_slow_i & common_ok & ~lowspd_sel_i;
      fwd_o     = sleep_req_i & ~busy_i & ~go_slow_o & ~go_fast_o;
   end

endmodule

// File: rtl/pwr_dt_settle.sv
module pwr_dt_settle #(
   parameter int SEL_W     = 3,
   parameter int MIN_EXP   = 3,
   parameter bit GATE_TICK = 1'b1,
   localparam int N_SEL    = 2 ** SEL_W,
   localparam int CNT_W    = MIN_EXP + N_SEL
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [SEL_W-1:0] sel_i,
   input  logic             tick_i,
   output logic             active_o,
   output logic             done_o
);

   logic [CNT_W-1:0] len_tbl [N_SEL];
   logic [CNT_W-1:0] cnt_q;
   logic             tick_w;

   for (genvar i = 0; i < N_SEL; i++) begin : g_tbl
      assign len_tbl[i] = CNT_W'(1) << (MIN_EXP + i);
   end

   if (GATE_TICK) begin : g_gated
      assign tick_w = tick_i;
   end else begin : g_free
      assign tick_w = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (start_i) begin
         cnt_q <= len_tbl[sel_i];
      end else if (active_o && tick_w) begin
         cnt_q <= cnt_q - CNT_W'(1);
      end
   end

   assign active_o = (cnt_q != '0);
   assign done_o   = active_o && tick_w && (cnt_q == CNT_W'(1));

   assert_hold_no_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (active_o && !tick_w && !start_i) |=> (cnt_q == $past(cnt_q)));

   assert_step_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (active_o && tick_w && !start_i) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

endmodule

// File: rtl/pwr_dt_ctrl.sv
module pwr_dt_ctrl
   import pwr_dt_pkg::*;
#(
   parameter int SEL_W     = 3,
   parameter int MIN_EXP   = 3,
   parameter bit GATE_TICK = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lspd_tick_i,
   input  logic             sleep_req_i,
   input  logic             stby_en_i,
   input  logic             lowspd_sel_i,
   input  logic             dt_en_i,
   input  logic             wdt_src_i,
   input  logic             div_sel_i,
   input  logic [SEL_W-1:0] settle_sel_i,
   output logic [1:0]       mode_o,
   output logic             clk_sel_o,
   output logic             busy_o,
   output logic             dt_irq_o,
   output logic             sleep_fwd_o,
   output logic             cpu_run_o
);

   if (SEL_W < 1 || SEL_W > 4) begin : g_bad_sel
      $error("pwr_dt_ctrl: SEL_W must lie in 1..4");
   end
   if (MIN_EXP < 1 || MIN_EXP > 12) begin : g_bad_exp
      $error("pwr_dt_ctrl: MIN_EXP must lie in 1..12");
   end

   dt_state_e state_q, state_d;
   logic      go_slow, go_fast, fwd_w;
   logic      settle_active, settle_done;
   logic      irq_q, fwd_q;

   pwr_dt_decode u_dec (
      .sleep_req_i  (sleep_req_i),
      .in_fast_i    (state_q == ST_FAST),
      .in_slow_i    (state_q == ST_SLOW),
      .busy_i       (state_q == ST_SETTLE),
      .div_sel_i    (div_sel_i),
      .stby_en_i    (stby_en_i),
      .lowspd_sel_i (lowspd_sel_i),
      .dt_en_i      (dt_en_i),
      .wdt_src_i    (wdt_src_i),
      .go_slow_o    (go_slow),
      .go_fast_o    (go_fast),
      .fwd_o        (fwd_w)
   );

   pwr_dt_settle #(
      .SEL_W     (SEL_W),
      .MIN_EXP   (MIN_EXP),
      .GATE_TICK (GATE_TICK)
   ) u_settle (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (go_fast),
      .sel_i    (settle_sel_i),
      .tick_i   (lspd_tick_i),
      .active_o (settle_active),
      .done_o   (settle_done)
   );

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_FAST:   if (go_slow) state_d = ST_SLOW;
         ST_SLOW:   if (go_fast) state_d = ST_SETTLE;
         ST_SETTLE: if (settle_done) state_d = ST_FAST;
         default:   state_d = ST_FAST;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_FAST;
         irq_q   <= 1'b0;
         fwd_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         irq_q   <= go_slow | ((state_q == ST_SETTLE) & settle_done);
         fwd_q   <= fwd_w;
      end
   end

   always_comb begin
      if (state_q == ST_FAST) begin
         mode_o = div_sel_i ? MODE_DIV : MODE_FULL;
      end else begin
         mode_o = MODE_LOW;
      end
   end

   assign clk_sel_o   = (state_q != ST_FAST);
   assign busy_o      = (state_q == ST_SETTLE);
   assign dt_irq_o    = irq_q;
   assign sleep_fwd_o = fwd_q;
   assign cpu_run_o   = 1'b1;

   assert_irq_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      dt_irq_o |=> !dt_irq_o);

   assert_irq_on_change_R6: assert property (@(posedge clk) disable iff (!rst_n)
      dt_irq_o |-> (state_q != $past(state_q)));

   assert_fwd_no_change_R8: assert property (@(posedge clk) disable iff (!rst_n)
      sleep_fwd_o |-> (state_q == $past(state_q) && !dt_irq_o));

   assert_settle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_SETTLE && !settle_done) |=> (state_q == ST_SETTLE));

   assert_settle_counter_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_SETTLE) |-> settle_active);

endmodule

// File: tb/tb_pwr_dt_ctrl.sv
module tb_pwr_dt_ctrl;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sleep_req = 1'b0, stby = 1'b0, lowspd = 1'b0, dten = 1'b0, wdt = 1'b0, divsel = 1'b0;
   logic [2:0] ssel = 3'd0;
   logic [1:0] mode;
   logic       clk_sel, busy, irq, fwd, run;
   logic       tick;
   int unsigned cyc = 0;
   int         tick_per = 1;
   int         n_vec = 0;
   int         n_bad = 0;

   always #10 clk = ~clk;

   always_ff @(posedge clk) cyc <= cyc + 1;
   assign tick = ((cyc % tick_per) == 0);

   pwr_dt_ctrl dut (
      .clk(clk), .rst_n(rst_n), .lspd_tick_i(tick), .sleep_req_i(sleep_req),
      .stby_en_i(stby), .lowspd_sel_i(lowspd), .dt_en_i(dten), .wdt_src_i(wdt),
      .div_sel_i(divsel), .settle_sel_i(ssel), .mode_o(mode), .clk_sel_o(clk_sel),
      .busy_o(busy), .dt_irq_o(irq), .sleep_fwd_o(fwd), .cpu_run_o(run)
   );

   task automatic chk(input string tag, input int act, input int exp);
      n_vec++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic set_bits(input logic s, input logic l, input logic d, input logic w);
      stby = s; lowspd = l; dten = d; wdt = w;
   endtask

   task automatic pulse_sleep();
      sleep_req = 1'b1;
      @(negedge clk);
      sleep_req = 1'b0;
   endtask

   task automatic t_reset();
      chk("R7 mode", mode, 0);
      chk("R7 clk_sel", clk_sel, 0);
      chk("R7 busy", busy, 0);
      chk("R7 irq", irq, 0);
      chk("R7 fwd", fwd, 0);
      chk("R5 run after reset", run, 1);
   endtask

   task automatic t_go_slow();
      set_bits(1, 1, 1, 1);
      pulse_sleep();
      chk("R2 mode low", mode, 2);
      chk("R2 clk_sel", clk_sel, 1);
      chk("R6 irq pulse", irq, 1);
      chk("R8 no fwd on direct", fwd, 0);
      chk("R5 run during switch", run, 1);
      @(negedge clk);
      chk("R6 irq one cycle", irq, 0);
   endtask

   task automatic t_forward(input string tag, input int exp_mode);
      pulse_sleep();
      chk({tag, " fwd pulse"}, fwd, 1);
      chk({tag, " mode kept"}, mode, exp_mode);
      chk({tag, " no irq"}, irq, 0);
      @(negedge clk);
      chk({tag, " fwd one cycle"}, fwd, 0);
   endtask

   task automatic t_settle(input logic [2:0] sel, input int per, input bit inject);
      int n = 0;
      int guard = 0;
      int bad_mode = 0;
      int fwd_seen = 0;
      tick_per = per;
      ssel = sel;
      set_bits(1, 0, 1, 1);
      pulse_sleep();
      chk("R3 busy raised", busy, 1);
      while (busy && guard < 20000) begin
         if (mode != 2 || clk_sel != 1 || run != 1) bad_mode++;
         if (fwd) fwd_seen++;
         if (tick) n++;
         if (inject && n == 3) begin
            set_bits(1, 1, 1, 1);
            sleep_req = 1'b1;
         end else begin
            sleep_req = 1'b0;
         end
         guard++;
         @(negedge clk);
      end
      sleep_req = 1'b0;
      chk("R4 tick count", n, 1 << (sel + 3));
      chk("R3 mode low while busy", bad_mode, 0);
      chk("R4 mode full after wait", mode, 0);
      chk("R4 clk_sel back", clk_sel, 0);
      chk("R6 irq on return", irq, 1);
      if (inject) chk("R9 no fwd while busy", fwd_seen, 0);
      @(negedge clk);
      chk("R6 irq cleared", irq, 0);
      tick_per = 1;
   endtask

   initial begin
      repeat (2) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();

      set_bits(1, 1, 0, 1);
      t_forward("R8 dt off", 0);
      set_bits(1, 1, 1, 0);
      t_forward("R8 wdt off", 0);

      divsel = 1'b1;
      @(negedge clk);
      chk("R1 divided mode", mode, 1);
      set_bits(1, 1, 1, 1);
      t_forward("R8 divided", 1);
      divsel = 1'b0;
      @(negedge clk);
      chk("R1 full mode", mode, 0);

      t_go_slow();
      set_bits(1, 1, 1, 1);
      t_forward("R8 low lowspd=1", 2);
      t_settle(3'd0, 1, 1'b0);

      t_go_slow();
      t_settle(3'd2, 3, 1'b1);

      t_go_slow();
      t_settle(3'd7, 1, 1'b0);

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=0", 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule